// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block merges level-sensitive interrupt sources into a small number of combined interrupt lines for a parent interrupt controller. With the default parameters it takes 32 sources and splits them into four groups of eight. Group g owns source bits [8g+7:8g] and drives one combined output. That output stays high for as long as any enabled source in its group is high. No acknowledge or clear is needed, because the output simply follows the levels.

Software reaches the block over a simple 32-bit register port made of a byte address, a write enable, write data and combinational read data. Enables change only through two separate addresses. One address sets every enable bit written as 1, and the other clears every enable bit written as 1. A single write can therefore mask one group with the byte mask 0xFF shifted to that group, and no read-modify-write sequence is needed.

A third address returns the pending status, which is each synchronised source level ANDed with its enable bit. Each source passes through a two-flop synchroniser before it is used.

Top module: `grp_irq_merge`

## Requirements
- R1: After reset all enable bits are 0, every group output is 0 and a status read returns 0.
- R2: A write to byte offset 0x0 sets every enable bit whose write-data bit is 1 and leaves all other enable bits unchanged.
- R3: A write to byte offset 0x4 clears every enable bit whose write-data bit is 1 and leaves all other enable bits unchanged.
- R4: A read of offset 0x0 or of offset 0x4 returns the current 32-bit enable mask, bit i belonging to source i.
- R5: A read of offset 0xC returns the status word, whose bit i is the synchronised level of source i ANDed with enable bit i.
- R6: Group output g (bit g of the output bus) is 1 exactly while at least one source in bits [8g+7:8g] is high and enabled, and it stays high with no acknowledge.
- R7: A change on a source input reaches the status word and the group output after exactly two rising clock edges.
- R8: A set or clear write changes the group output and the status word immediately after the clock edge that accepts the write.
- R9: Writes to any offset other than 0x0 and 0x4 leave the enables unchanged, and reads of any offset other than 0x0, 0x4 and 0xC return 0.
- R10: The sources and enables of one group never affect the output of another group.
- R11: A single write of 0xFF shifted left by 8g to offset 0x4 disables all eight sources of group g and drops its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive interrupt sources, asynchronous to clk |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| grp_irq_o | output | 4 | One combined interrupt line per group |

## Verification
A source change is applied at a falling edge. The bench then lets two rising edges pass and samples at the following falling edge. It also samples once after only one rising edge, to confirm that the output has not moved early. Set and clear writes are sampled at the falling edge right after the accepting rising edge, where the new enables must already show on the outputs. Read data is combinational, so it is sampled 1 ns after the address is applied in the low half of the clock.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    localparam int unsigned GRP_COUNT = 4;
    localparam int unsigned GRP_WIDTH = 8;
    localparam int unsigned REG_ADDR_W = 4;

    localparam int unsigned OFS_EN_SET = 32'h0;
    localparam int unsigned OFS_EN_CLR = 32'h4;
    localparam int unsigned OFS_STATUS = 32'hC;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_STAT = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/irqm_sync.sv
module irqm_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q[b] <= 1'b0;
                stage2_q[b] <= 1'b0;
            end else begin
                stage1_q[b] <= async_i[b];
                stage2_q[b] <= stage1_q[b];
            end
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/irqm_enable_regs.sv
module irqm_enable_regs #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [WIDTH-1:0]  status_i,
    output logic [WIDTH-1:0]  en_o,
    output logic [WIDTH-1:0]  rdata_o
);
    import irqm_pkg::*;

    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_EN_CLR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

    acc_kind_e        acc;
    logic [WIDTH-1:0] en_q;

    always_comb begin
        if (addr_i == A_SET)       acc = ACC_SET;
        else if (addr_i == A_CLR)  acc = ACC_CLR;
        else if (addr_i == A_STAT) acc = ACC_STAT;
        else                       acc = ACC_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (we_i) begin
            unique case (acc)
                ACC_SET:  en_q <= en_q | wdata_i;
                ACC_CLR:  en_q <= en_q & ~wdata_i;
                ACC_STAT: en_q <= en_q;
                ACC_NONE: en_q <= en_q;
            endcase
        end
    end

    always_comb begin
        unique case (acc)
            ACC_SET:  rdata_o = en_q;
            ACC_CLR:  rdata_o = en_q;
            ACC_STAT: rdata_o = status_i;
            ACC_NONE: rdata_o = '0;
        endcase
    end

    assign en_o = en_q;

    // R2
    set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && acc == ACC_SET) |=> ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));

    // R2
    set_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && acc == ACC_SET) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

    // R3
    clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && acc == ACC_CLR) |=> ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));

    // R3
    clr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && acc == ACC_CLR) |=> ((en_q & $past(wdata_i)) == '0));

    // R9
    other_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i || (acc != ACC_SET && acc != ACC_CLR)) |=> $stable(en_q));

endmodule

// File: rtl/irqm_group.sv
module irqm_group #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] en_i,
    output logic             irq_o
);

    logic [WIDTH-1:0] pend;

    always_comb begin
        pend  = lvl_i & en_i;
        irq_o = |pend;
    end

    // R6
    grp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> !irq_o);

    // R6
    grp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_i & en_i) != '0) |-> irq_o);

endmodule

// File: rtl/grp_irq_merge.sv
module grp_irq_merge #(
    parameter int unsigned GROUPS  = irqm_pkg::GRP_COUNT,
    parameter int unsigned GROUP_W = irqm_pkg::GRP_WIDTH,
    parameter int unsigned ADDR_W  = irqm_pkg::REG_ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [GROUPS*GROUP_W-1:0]     src_i,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [GROUPS*GROUP_W-1:0]     bus_wdata,
    output logic [GROUPS*GROUP_W-1:0]     bus_rdata,
    output logic [GROUPS-1:0]             grp_irq_o
);

    localparam int unsigned NSRC = GROUPS * GROUP_W;

    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] status;

    irqm_sync #(.WIDTH(NSRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (lvl)
    );

    assign status = lvl & en;

    irqm_enable_regs #(.WIDTH(NSRC), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .wdata_i  (bus_wdata),
        .status_i (status),
        .en_o     (en),
        .rdata_o  (bus_rdata)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        irqm_group #(.WIDTH(GROUP_W)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl_i (lvl[g*GROUP_W +: GROUP_W]),
            .en_i  (en[g*GROUP_W +: GROUP_W]),
            .irq_o (grp_irq_o[g])
        );
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (grp_irq_o == '0));

endmodule

// File: tb/grp_irq_merge_bench.sv
module grp_irq_merge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [3:0]  addr = 4'h8;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    grp_irq_merge u_grp_irq_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .grp_irq_o (irq)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] setm;
        logic [31:0] clrm;
        logic [31:0] en;
        logic [3:0]  irq;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{32'h0000_00FF, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 4'b0001},
        '{32'h0000_00FF, 32'h0101_0100, 32'h0000_0000, 32'h0101_0101, 4'b0001},
        '{32'hFF00_0100, 32'h0000_0000, 32'h0000_0000, 32'h0101_0101, 4'b1010},
        '{32'hFF00_0100, 32'h0000_0000, 32'h0000_FF00, 32'h0101_0001, 4'b1000},
        '{32'h00FF_0000, 32'h00F0_0000, 32'h0000_0000, 32'h01F1_0001, 4'b0100},
        '{32'h0080_0000, 32'h0000_0000, 32'h0070_0000, 32'h0181_0001, 4'b0100},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFF00_0000, 32'h00FF_FFFF, 4'b0111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; addr = 4'h8; wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = 4'h8;
    endtask

    task automatic settle;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        src = 32'hFFFF_FFFF;
        settle();
        // R1 reset state
        bus_rd(4'h0, rd); chk("R1 enables", rd, 32'h0);
        bus_rd(4'hC, rd); chk("R1 status", rd, 32'h0);
        chk("R1 outputs", {28'h0, irq}, 32'h0);
        @(negedge clk);
        src = '0;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            src = VEC[i].src;
            bus_wr(4'h0, VEC[i].setm);
            bus_wr(4'h4, VEC[i].clrm);
            settle();
            bus_rd(4'h0, rd); chk("R2/R3 enable mask", rd, VEC[i].en);
            bus_rd(4'h4, rd); chk("R4 read at clear offset", rd, VEC[i].en);
            bus_rd(4'hC, rd); chk("R5 status", rd, VEC[i].src & VEC[i].en);
            chk("R6 R10 group outputs", {28'h0, irq}, {28'h0, VEC[i].irq});
        end

        // R11 and R8: one clear write masks group 1 right after the edge
        bus_wr(4'h4, 32'hFF << 8);
        chk("R11 group clear", {28'h0, irq}, 32'b0101);
        bus_wr(4'h0, 32'hFF00_0000);
        chk("R8 set takes effect next cycle", {28'h0, irq}, 32'b1101);

        // R9 writes elsewhere ignored, reads elsewhere zero
        bus_wr(4'h8, 32'hFFFF_FFFF);
        bus_wr(4'hC, 32'h0000_0000);
        bus_wr(4'h2, 32'h0000_0000);
        bus_rd(4'h0, rd); chk("R9 enables untouched", rd, 32'hFFFF_00FF);
        bus_rd(4'h8, rd); chk("R9 read other offset", rd, 32'h0);
        bus_rd(4'h1, rd); chk("R9 read unaligned offset", rd, 32'h0);

        // R7 two-edge latency, falling
        @(negedge clk);
        src = '0;
        @(posedge clk); @(negedge clk);
        chk("R7 no change after one edge", {28'h0, irq}, 32'b1101);
        @(posedge clk); @(negedge clk);
        chk("R7 drop after two edges", {28'h0, irq}, 32'b0000);

        // R7 rising, single source in group 0
        src = 32'h0000_0004;
        @(posedge clk); @(negedge clk);
        chk("R7 no rise after one edge", {28'h0, irq}, 32'b0000);
        @(posedge clk); @(negedge clk);
        chk("R7 rise after two edges", {28'h0, irq}, 32'b0001);

        // R6 level held with no acknowledge
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R6 held without acknowledge", {28'h0, irq}, 32'b0001);

        // R10 disabled group-1 source does not leak
        src = 32'h0000_FF04;
        settle();
        chk("R10 isolation", {28'h0, irq}, 32'b0001);

        // R1 reset mid-run clears enables
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        bus_rd(4'h4, rd); chk("R1 enables after reset", rd, 32'h0);
        chk("R1 outputs after reset", {28'h0, irq}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule